// File: doc/BRIEF.md
# Two-Thread Congestion Throttle

This block sits beside the decode stage of a core that runs two hardware threads at once. It decides when a thread is congesting shared back-end resources and holds that thread back. Each thread reports single-cycle pulses for second-level cache load misses and translation misses, together with a live count of the reorder-buffer entries it holds. The block judges each thread over a programmable window of cycles. At every window boundary it moves the thread's throttle level one step up while congestion persists, or returns it to zero after a clean window.

There are four levels. The first only lowers the thread's decode priority. The second also blocks decode. The third adds a one-cycle flush of the thread's instructions that are waiting for dispatch, and decode stays blocked. A small arbiter turns the levels into a per-cycle decode slot grant, so a lowered thread receives fewer decode cycles and a blocked thread receives none. The block never blocks decode for both threads at the same time.

Top module: `smt_congestion_throttle`

## Requirements
- R1: During and directly after reset every thread is at level 0, no priority, hold or flush output is active, and the decode slot is granted to thread 0 (`decode_slot` = 2'b01).
- R2: A window ends in every cycle in which the window count plus one is at least `cfg_win_len` (a value of 0 behaves as 1). The count then restarts at zero, and the per-thread miss count and occupancy flag clear for the next window.
- R3: A thread is miss-congested at a window end when its L2 and TLB miss pulses within the window, counting the end cycle and counting two when both pulse in one cycle, total at least `cfg_miss_limit`.
- R4: A thread is occupancy-congested at a window end when its reorder-buffer occupancy was at least `cfg_rob_limit` in any cycle of that window, the end cycle included.
- R5: At a window end a congested thread's level rises by exactly one, saturating at 3. A thread congested by neither rule returns to level 0. The level of thread t is reported on `throttle_lvl[2t+1:2t]`.
- R6: `prio_low[t]` is high at levels 1 to 3, and `decode_hold[t]` is high at levels 2 and 3.
- R7: `dispatch_flush[t]` is high for exactly the first cycle in which thread t is at level 3.
- R8: If a window end would leave both threads at level 2 or above, the thread with the lower occupancy in that cycle goes to level 0 instead, thread 0 on a tie. `decode_hold` is therefore never high for both threads.
- R9: `decode_slot` is one-hot or zero and never grants a held thread. If only one thread is eligible, it gets every cycle. Two eligible threads at equal priority alternate each cycle, starting with thread 0 after reset. If one eligible thread has lowered priority and the other does not, the lowered thread gets the slot only in the cycle where a free-running 2-bit phase counter, cleared by reset, equals 3.
- R10: Throttle levels change only in the cycle that follows a window end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win_len | input | WIN_W | Window length in cycles |
| cfg_miss_limit | input | CNT_W | Miss total that marks a thread congested |
| cfg_rob_limit | input | ROB_W | Occupancy that marks a thread congested |
| l2_miss_pulse | input | 2 | Per-thread L2 load miss event |
| tlb_miss_pulse | input | 2 | Per-thread TLB miss event |
| rob_occ_t0 | input | ROB_W | Reorder-buffer entries held by thread 0 |
| rob_occ_t1 | input | ROB_W | Reorder-buffer entries held by thread 1 |
| prio_low | output | 2 | Per-thread lowered decode priority |
| decode_hold | output | 2 | Per-thread decode block |
| dispatch_flush | output | 2 | Per-thread one-cycle flush of pending dispatch |
| decode_slot | output | 2 | Per-cycle decode grant, one-hot or zero |
| throttle_lvl | output | 4 | Two-bit level per thread |

## Verification
A wrong miss count or a stale occupancy flag shows up only at the next window end, as a level that rises when it should reset or stays at zero when it should rise. It is seen on `throttle_lvl` one cycle after that boundary. A wrong level then affects `prio_low`, `decode_hold` and the decode slot pattern in the same cycle, and a missed or repeated flush appears as a pulse on the wrong cycle. Because the grant depends on the phase and alternation registers, a slip in the arbiter state is visible at `decode_slot` in the very next cycle.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int NTHR = 2;

    typedef enum logic [1:0] {
        LVL_NONE   = 2'd0,
        LVL_LOWPRI = 2'd1,
        LVL_HOLD   = 2'd2,
        LVL_FLUSH  = 2'd3
    } thr_lvl_e;
endpackage

// File: rtl/thr_window.sv
module thr_window #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_len_i,
    output logic             win_end_o
);
    typedef struct packed {
        logic [WIN_W-1:0] cnt;
    } win_st_t;

    win_st_t q, d;

    always_comb begin
        d         = q;
        win_end_o = ({1'b0, q.cnt} + 1'b1) >= {1'b0, win_len_i};
        if (win_end_o) d.cnt = '0;
        else           d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/thr_monitor.sv
module thr_monitor #(
    parameter int CNT_W = 6,
    parameter int ROB_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_end_i,
    input  logic             l2_i,
    input  logic             tlb_i,
    input  logic [ROB_W-1:0] occ_i,
    input  logic [CNT_W-1:0] miss_limit_i,
    input  logic [ROB_W-1:0] rob_limit_i,
    output logic             congested_o
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] miss;
        logic             hot;
    } mon_st_t;

    mon_st_t q, d;
    logic [SUM_W-1:0] sum;
    logic             hot_now;

    always_comb begin
        d       = q;
        sum     = {1'b0, q.miss} + SUM_W'(l2_i) + SUM_W'(tlb_i);
        hot_now = q.hot | (occ_i >= rob_limit_i);
        congested_o = (sum >= {1'b0, miss_limit_i}) | hot_now;
        if (win_end_i) begin
            d.miss = '0;
            d.hot  = 1'b0;
        end else begin
            d.miss = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
            d.hot  = hot_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/thr_level_ctrl.sv
module thr_level_ctrl
    import thr_pkg::*;
#(
    parameter int ROB_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 win_end_i,
    input  logic [NTHR-1:0]      cong_i,
    input  logic [ROB_W-1:0]     occ0_i,
    input  logic [ROB_W-1:0]     occ1_i,
    output logic [2*NTHR-1:0]    lvl_o,
    output logic [NTHR-1:0]      prio_low_o,
    output logic [NTHR-1:0]      hold_o,
    output logic [NTHR-1:0]      flush_o
);
    typedef struct packed {
        thr_lvl_e [NTHR-1:0] lvl;
        logic     [NTHR-1:0] flush;
    } lvl_st_t;

    lvl_st_t q, d;
    logic    keep;

    always_comb begin
        d    = q;
        keep = occ1_i < occ0_i;
        for (int t = 0; t < NTHR; t++) begin
            if (win_end_i) begin
                if (!cong_i[t])                 d.lvl[t] = LVL_NONE;
                else if (q.lvl[t] == LVL_FLUSH) d.lvl[t] = LVL_FLUSH;
                else                            d.lvl[t] = thr_lvl_e'(q.lvl[t] + 2'd1);
            end
        end
        if (d.lvl[0] >= LVL_HOLD && d.lvl[1] >= LVL_HOLD) begin
            d.lvl[keep] = LVL_NONE;
        end
        for (int t = 0; t < NTHR; t++) begin
            d.flush[t] = (d.lvl[t] == LVL_FLUSH) && (q.lvl[t] != LVL_FLUSH);
        end
    end

    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            lvl_o[2*t +: 2] = q.lvl[t];
            prio_low_o[t]   = q.lvl[t] != LVL_NONE;
            hold_o[t]       = q.lvl[t] >= LVL_HOLD;
            flush_o[t]      = q.flush[t];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    excl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_o[0] && hold_o[1]));

    // R10
    lvl_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(win_end_i) |-> $stable(lvl_o));

    for (genvar g = 0; g < NTHR; g++) begin : g_chk
        // R7
        flush_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flush_o[g] |-> (lvl_o[2*g +: 2] == 2'd3) && ($past(lvl_o[2*g +: 2]) != 2'd3));
        // R5
        lvl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_o[2*g +: 2] > $past(lvl_o[2*g +: 2])) |->
            (int'(lvl_o[2*g +: 2]) == int'($past(lvl_o[2*g +: 2])) + 1));
    end
endmodule

// File: rtl/thr_decode_arb.sv
module thr_decode_arb
    import thr_pkg::*;
#(
    parameter int SHARE_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTHR-1:0] low_i,
    input  logic [NTHR-1:0] hold_i,
    output logic [NTHR-1:0] slot_o
);
    localparam logic [SHARE_W-1:0] PH_LAST = '1;

    typedef struct packed {
        logic               rr;
        logic [SHARE_W-1:0] ph;
    } arb_st_t;

    arb_st_t q, d;
    logic [NTHR-1:0] lowered;

    always_comb begin
        d       = q;
        d.rr    = ~q.rr;
        d.ph    = q.ph + 1'b1;
        lowered = low_i & ~hold_i;
        if (hold_i[0] && hold_i[1])   slot_o = 2'b00;
        else if (hold_i[0])           slot_o = 2'b10;
        else if (hold_i[1])           slot_o = 2'b01;
        else if (lowered[0] == lowered[1])
            slot_o = q.rr ? 2'b10 : 2'b01;
        else if (lowered[0])
            slot_o = (q.ph == PH_LAST) ? 2'b01 : 2'b10;
        else
            slot_o = (q.ph == PH_LAST) ? 2'b10 : 2'b01;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9
    slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_o));
    // R9
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o & hold_i) == '0);
endmodule

// File: rtl/smt_congestion_throttle.sv
module smt_congestion_throttle
    import thr_pkg::*;
#(
    parameter int WIN_W   = 8,
    parameter int CNT_W   = 6,
    parameter int ROB_W   = 7,
    parameter int SHARE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] cfg_win_len,
    input  logic [CNT_W-1:0] cfg_miss_limit,
    input  logic [ROB_W-1:0] cfg_rob_limit,
    input  logic [1:0]       l2_miss_pulse,
    input  logic [1:0]       tlb_miss_pulse,
    input  logic [ROB_W-1:0] rob_occ_t0,
    input  logic [ROB_W-1:0] rob_occ_t1,
    output logic [1:0]       prio_low,
    output logic [1:0]       decode_hold,
    output logic [1:0]       dispatch_flush,
    output logic [1:0]       decode_slot,
    output logic [3:0]       throttle_lvl
);
    logic             win_end;
    logic [NTHR-1:0]  cong;
    logic [ROB_W-1:0] occ [NTHR];

    assign occ[0] = rob_occ_t0;
    assign occ[1] = rob_occ_t1;

    thr_window #(.WIN_W(WIN_W)) i_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_len_i (cfg_win_len),
        .win_end_o (win_end)
    );

    for (genvar t = 0; t < NTHR; t++) begin : g_mon
        thr_monitor #(.CNT_W(CNT_W), .ROB_W(ROB_W)) i_monitor (
            .clk          (clk),
            .rst_n        (rst_n),
            .win_end_i    (win_end),
            .l2_i         (l2_miss_pulse[t]),
            .tlb_i        (tlb_miss_pulse[t]),
            .occ_i        (occ[t]),
            .miss_limit_i (cfg_miss_limit),
            .rob_limit_i  (cfg_rob_limit),
            .congested_o  (cong[t])
        );
    end

    thr_level_ctrl #(.ROB_W(ROB_W)) i_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_end_i  (win_end),
        .cong_i     (cong),
        .occ0_i     (rob_occ_t0),
        .occ1_i     (rob_occ_t1),
        .lvl_o      (throttle_lvl),
        .prio_low_o (prio_low),
        .hold_o     (decode_hold),
        .flush_o    (dispatch_flush)
    );

    thr_decode_arb #(.SHARE_W(SHARE_W)) i_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .low_i  (prio_low),
        .hold_i (decode_hold),
        .slot_o (decode_slot)
    );
endmodule

// File: tb/test_smt_congestion_throttle.sv
module test_smt_congestion_throttle;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_win_len = 8'd8;
    logic [5:0] cfg_miss_limit = 6'd3;
    logic [6:0] cfg_rob_limit = 7'd100;
    logic [1:0] l2_miss_pulse = '0;
    logic [1:0] tlb_miss_pulse = '0;
    logic [6:0] rob_occ_t0 = '0;
    logic [6:0] rob_occ_t1 = '0;
    logic [1:0] prio_low, decode_hold, dispatch_flush, decode_slot;
    logic [3:0] throttle_lvl;

    int n_cmp = 0;
    int n_err = 0;

    // reference state, built from the requirements
    int m_win;
    int m_miss [2];
    int m_hot  [2];
    int m_lvl  [2];
    int m_flush[2];
    int m_rr;
    int m_ph;

    always #10 clk = ~clk;

    smt_congestion_throttle i_smt_congestion_throttle (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_win_len    (cfg_win_len),
        .cfg_miss_limit (cfg_miss_limit),
        .cfg_rob_limit  (cfg_rob_limit),
        .l2_miss_pulse  (l2_miss_pulse),
        .tlb_miss_pulse (tlb_miss_pulse),
        .rob_occ_t0     (rob_occ_t0),
        .rob_occ_t1     (rob_occ_t1),
        .prio_low       (prio_low),
        .decode_hold    (decode_hold),
        .dispatch_flush (dispatch_flush),
        .decode_slot    (decode_slot),
        .throttle_lvl   (throttle_lvl)
    );

    function automatic int exp_slot(int l0, int l1, int rr, int ph);
        int h0 = (l0 >= 2);
        int h1 = (l1 >= 2);
        int w0 = (l0 == 1);
        int w1 = (l1 == 1);
        if (h0 && h1) return 0;
        if (h0) return 2;
        if (h1) return 1;
        if (w0 == w1) return rr ? 2 : 1;
        if (w0) return (ph == 3) ? 1 : 2;
        return (ph == 3) ? 2 : 1;
    endfunction

    always @(posedge clk) begin
        int e;
        int sum;
        int hot;
        int cg [2];
        int nl [2];
        int occ [2];
        int keep;
        if (!rst_n) begin
            m_win = 0; m_rr = 0; m_ph = 0;
            for (int t = 0; t < 2; t++) begin
                m_miss[t] = 0; m_hot[t] = 0; m_lvl[t] = 0; m_flush[t] = 0;
            end
        end else begin
            occ[0] = rob_occ_t0;
            occ[1] = rob_occ_t1;
            // R2: window boundary rule
            e = ((m_win + 1) >= int'(cfg_win_len));
            for (int t = 0; t < 2; t++) begin
                // R3, R4: congestion rules
                sum = m_miss[t] + l2_miss_pulse[t] + tlb_miss_pulse[t];
                hot = m_hot[t] | (occ[t] >= int'(cfg_rob_limit));
                cg[t] = (sum >= int'(cfg_miss_limit)) || hot;
                m_miss[t] = e ? 0 : ((sum > 63) ? 63 : sum);
                m_hot[t]  = e ? 0 : hot;
                // R5
                nl[t] = e ? (cg[t] ? ((m_lvl[t] == 3) ? 3 : m_lvl[t] + 1) : 0) : m_lvl[t];
            end
            // R8
            if (nl[0] >= 2 && nl[1] >= 2) begin
                keep = (occ[1] < occ[0]) ? 1 : 0;
                nl[keep] = 0;
            end
            for (int t = 0; t < 2; t++) begin
                m_flush[t] = (nl[t] == 3 && m_lvl[t] != 3);
                m_lvl[t]   = nl[t];
            end
            m_win = e ? 0 : m_win + 1;
            m_rr  = 1 - m_rr;
            m_ph  = (m_ph + 1) % 4;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        for (int t = 0; t < 2; t++) begin
            chk("R2 R3 R4 R5 R10 level", int'(throttle_lvl[2*t +: 2]), m_lvl[t]);
            chk("R6 prio_low", int'(prio_low[t]), int'(m_lvl[t] >= 1));
            chk("R6 decode_hold", int'(decode_hold[t]), int'(m_lvl[t] >= 2));
            chk("R7 flush", int'(dispatch_flush[t]), m_flush[t]);
        end
        chk("R8 hold exclusive", int'(decode_hold == 2'b11), 0);
        chk("R9 decode slot", int'(decode_slot), exp_slot(m_lvl[0], m_lvl[1], m_rr, m_ph));
    endtask

    // p*: percent chance of a pulse; occupancy drawn from [lo,hi]
    task automatic run(int n, int pl0, int pl1, int pt0, int pt1,
                       int lo0, int hi0, int lo1, int hi1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
            l2_miss_pulse[0]  = ($urandom % 100) < pl0;
            l2_miss_pulse[1]  = ($urandom % 100) < pl1;
            tlb_miss_pulse[0] = ($urandom % 100) < pt0;
            tlb_miss_pulse[1] = ($urandom % 100) < pt1;
            rob_occ_t0 = 7'(lo0 + ($urandom % (hi0 - lo0 + 1)));
            rob_occ_t1 = 7'(lo1 + ($urandom % (hi1 - lo1 + 1)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 level", int'(throttle_lvl), 0);
        chk("R1 prio/hold/flush", int'({prio_low, decode_hold, dispatch_flush}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 slot after reset", int'(decode_slot), 2);
        chk("R1 level after reset", int'(throttle_lvl), 0);

        // quiet start
        run(20, 0, 0, 0, 0, 0, 20, 0, 20);
        // thread 0 miss storm: escalate to flush (R3, R5, R7)
        run(40, 60, 0, 30, 0, 0, 20, 0, 20);
        // clean windows: back to zero (R5)
        run(16, 0, 0, 0, 0, 0, 20, 0, 20);
        // both storm, thread 1 lower occupancy stays free (R8)
        run(48, 60, 60, 30, 30, 80, 90, 10, 20);
        run(16, 0, 0, 0, 0, 0, 20, 0, 20);
        // occupancy trigger only on thread 1 (R4)
        run(40, 0, 0, 0, 0, 0, 20, 110, 127);
        run(16, 0, 0, 0, 0, 0, 20, 0, 20);
        // tie in occupancy: thread 0 stays free (R8)
        run(40, 70, 70, 0, 0, 50, 50, 50, 50);
        // one-cycle windows (R2)
        cfg_win_len = 8'd0; cfg_miss_limit = 6'd1;
        run(30, 30, 30, 10, 10, 0, 60, 0, 60);
        cfg_win_len = 8'd1;
        run(30, 20, 40, 10, 10, 0, 60, 0, 60);
        // limit zero: always congested (R3)
        cfg_win_len = 8'd5; cfg_miss_limit = 6'd0;
        run(40, 0, 0, 0, 0, 0, 40, 0, 40);
        // random phases with changing settings
        for (int k = 0; k < 20; k++) begin
            cfg_win_len    = 8'($urandom % 16);
            cfg_miss_limit = 6'($urandom % 8);
            cfg_rob_limit  = 7'(60 + ($urandom % 68));
            run(200, $urandom % 50, $urandom % 50, $urandom % 30, $urandom % 30,
                0, 80, 0, 127);
        end
        @(negedge clk);
        check_all();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule